// File: doc/BRIEF.md
# Mode Unlock and Register Bank Selector

This block watches the byte writes that a host issues to a small port-addressed register interface. It decides whether that interface runs in its standard mode or in an enhanced mode. After reset the interface is in standard mode. Enhanced mode opens only when four writes to the control port carry a fixed key, in order. Writes to other ports may fall between the key writes.

After the unlock, the control port changes role and becomes a bank selector. A byte written there picks which of three register banks the other ports decode into. The bank registers are outside this block. It only supplies the mode flag and the bank number, both registered, so they change one clock after the write that causes the change.

Top module: `mode_bank_unlock`

## Requirements
- R1: While reset is asserted, and right after it is released, `enh_mode` is 0 and `bank_sel` is 0. A reset also discards any partly matched key.
- R2: In standard mode, writes to port 7 carrying 07h, 0Dh, 06h and 12h, in that order, set `enh_mode` to 1 on the clock edge of the last write. No other byte may be written to port 7 in between.
- R3: On the edge where enhanced mode is entered, `bank_sel` is 0.
- R4: In standard mode, a port-7 byte that is not the next expected key byte restarts the match. If that byte is 07h, it counts as the first key byte.
- R5: In standard mode, writes to any port other than 7 neither advance nor break a partly matched key.
- R6: In enhanced mode, a port-7 write of 00h, 40h or 80h sets `bank_sel` to 0, 1 or 2, one clock later. `bank_sel` never reads 3.
- R7: In enhanced mode, a port-7 byte other than those three codes leaves `bank_sel` unchanged. Writes to other ports also leave it unchanged.
- R8: Once set, `enh_mode` stays 1 until reset, whatever is written. Key bytes written again have no effect.
- R9: In standard mode, `bank_sel` stays 0, even when bank codes are written to port 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_port | input | 3 | Port address of the write |
| wr_data | input | 8 | Data byte of the write |
| enh_mode | output | 1 | 1 when enhanced mode is unlocked |
| bank_sel | output | 2 | Active register bank (0, 1 or 2) |

## Verification
The assertions check the cycle-level rules on every clock:
- `bank_sel` stays at 0 in standard mode and never takes the value 3.
- Enhanced mode never drops once it is set.
- The unlock edge follows a port-7 write of the last key byte made while the match sat at its final position.
- A foreign port-7 byte that is not 07h clears the match.
- Idle cycles and writes to other ports keep the match position and the bank steady.

The scenarios in the bench cover what needs a whole history. They check that only the complete ordered key unlocks, that 07h restarts the match at the first byte, and that interleaved writes to other ports are tolerated. They also check that a reset discards a half-entered key, and which bank each code selects.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int KEY_LEN   = 4;
  localparam int KEY_POS_W = $clog2(KEY_LEN);
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 3;

  // Unlock key, written to the control port in this order.
  function automatic logic [7:0] key_byte(input int unsigned idx);
    case (idx)
      0:       key_byte = 8'h07;
      1:       key_byte = 8'h0D;
      2:       key_byte = 8'h06;
      default: key_byte = 8'h12;
    endcase
  endfunction

  // A bank code carries the bank number in the top two bits, with the rest zero.
  function automatic logic bank_code_ok(input logic [7:0] data);
    bank_code_ok = (data[5:0] == 6'd0) && (int'(data[7:6]) < NUM_BANKS);
  endfunction

  function automatic logic [BANK_W-1:0] bank_code_val(input logic [7:0] data);
    bank_code_val = data[7:6];
  endfunction

endpackage

// File: rtl/mbs_wr_decode.sv
module mbs_wr_decode #(
  parameter int PORT_W    = 3,
  parameter int CTRL_PORT = 7
) (
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              enh_mode,
  output logic              key_step,
  output logic              bank_step
);
  logic ctrl_hit;

  always_comb begin
    ctrl_hit  = wr_en && (wr_port == PORT_W'(CTRL_PORT));
    key_step  = ctrl_hit && !enh_mode;
    bank_step = ctrl_hit &&  enh_mode;
  end
endmodule

// File: rtl/mbs_key_seq.sv
module mbs_key_seq
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [DATA_W-1:0]    data,
  output logic [KEY_POS_W-1:0] pos,
  output logic                 unlock
);
  localparam logic [KEY_POS_W-1:0] LAST_POS = KEY_POS_W'(KEY_LEN - 1);

  logic [KEY_LEN-1:0]   hit;
  logic [KEY_POS_W-1:0] pos_nxt;

  for (genvar i = 0; i < KEY_LEN; i++) begin : g_cmp
    assign hit[i] = (data[7:0] == key_byte(i));
  end

  always_comb begin
    pos_nxt = pos;
    unlock  = 1'b0;
    if (step) begin
      if (hit[pos]) begin
        if (pos == LAST_POS) begin
          unlock  = 1'b1;
          pos_nxt = '0;
        end else begin
          pos_nxt = pos + KEY_POS_W'(1);
        end
      end else if (hit[0]) begin
        pos_nxt = KEY_POS_W'(1);
      end else begin
        pos_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end
endmodule

// File: rtl/mbs_bank_reg.sv
module mbs_bank_reg
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              bank_step,
  input  logic [DATA_W-1:0] data,
  output logic              enh_mode,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enh_mode <= 1'b0;
      bank     <= '0;
    end else if (unlock) begin
      enh_mode <= 1'b1;
      bank     <= '0;
    end else if (bank_step && bank_code_ok(data[7:0])) begin
      bank     <= bank_code_val(data[7:0]);
    end
  end
endmodule

// File: rtl/mode_bank_unlock.sv
module mode_bank_unlock
  import mbs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PORT_W    = 3,
  parameter int CTRL_PORT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enh_mode,
  output logic [BANK_W-1:0] bank_sel
);
  // Named internal events, observed by the bound checker.
  logic                 key_step;
  logic                 bank_step;
  logic                 unlock_evt;
  logic [KEY_POS_W-1:0] seq_pos;

  mbs_wr_decode #(.PORT_W(PORT_W), .CTRL_PORT(CTRL_PORT)) u_dec (
    .wr_en     (wr_en),
    .wr_port   (wr_port),
    .enh_mode  (enh_mode),
    .key_step  (key_step),
    .bank_step (bank_step)
  );

  mbs_key_seq #(.DATA_W(DATA_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (key_step),
    .data   (wr_data),
    .pos    (seq_pos),
    .unlock (unlock_evt)
  );

  mbs_bank_reg #(.DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .unlock    (unlock_evt),
    .bank_step (bank_step),
    .data      (wr_data),
    .enh_mode  (enh_mode),
    .bank      (bank_sel)
  );
endmodule

// File: rtl/mode_bank_unlock_chk.sv
module mode_bank_unlock_chk
  import mbs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PORT_W    = 3,
  parameter int CTRL_PORT = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [PORT_W-1:0]    wr_port,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 enh_mode,
  input logic [BANK_W-1:0]    bank_sel,
  input logic [KEY_POS_W-1:0] seq_pos,
  input logic                 bank_step
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_port == PORT_W'(CTRL_PORT));

  assert_std_bank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> bank_sel == '0);

  assert_bank_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel != 2'd3);

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode);

  assert_unlock_bank_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> bank_sel == '0);

  assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(ctrl_wr && wr_data[7:0] == key_byte(KEY_LEN - 1)
                              && int'(seq_pos) == KEY_LEN - 1));

  assert_wrong_byte_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode && ctrl_wr && wr_data[7:0] != key_byte(int'(seq_pos))
     && wr_data[7:0] != key_byte(0)) |=> seq_pos == '0);

  assert_other_port_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode && !ctrl_wr) |=> $stable(seq_pos));

  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && !bank_step) |=> $stable(bank_sel));
endmodule

bind mode_bank_unlock mode_bank_unlock_chk #(
  .DATA_W(DATA_W), .PORT_W(PORT_W), .CTRL_PORT(CTRL_PORT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_port   (wr_port),
  .wr_data   (wr_data),
  .enh_mode  (enh_mode),
  .bank_sel  (bank_sel),
  .seq_pos   (seq_pos),
  .bank_step (bank_step)
);

// File: tb/mode_bank_unlock_bench.sv
module mode_bank_unlock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_port = '0;
  logic [7:0] wr_data = '0;
  logic       enh_mode;
  logic [1:0] bank_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic       mode;
    logic [1:0] bank;
    int         due;
    string      tag;
  } exp_t;
  exp_t q[$];

  // Reference model: keeps the last four control-port bytes seen in standard mode.
  logic [31:0] hist = '0;
  logic        m_mode = 1'b0;
  logic [1:0]  m_bank = '0;

  mode_bank_unlock u_mode_bank_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .enh_mode(enh_mode), .bank_sel(bank_sel)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations whose edge has passed and compares them.
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (enh_mode !== e.mode || bank_sel !== e.bank) begin
        errors++;
        $display("FAIL %s: got mode=%0b bank=%0d, expected mode=%0b bank=%0d",
                 e.tag, enh_mode, bank_sel, e.mode, e.bank);
      end
    end
  end

  task automatic wr(input logic [2:0] p, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    if (p == 3'd7) begin
      if (!m_mode) begin
        hist = {hist[23:0], d};
        if (hist == 32'h070D0612) begin m_mode = 1'b1; m_bank = 2'd0; end
      end else if (d == 8'h00) m_bank = 2'd0;
      else if (d == 8'h40) m_bank = 2'd1;
      else if (d == 8'h80) m_bank = 2'd2;
    end
    e.mode = m_mode; e.bank = m_bank; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(2);
    rst_n = 1'b0;
    hist = '0; m_mode = 1'b0; m_bank = '0;
    @(negedge clk);
    checks++;
    if (enh_mode !== 1'b0 || bank_sel !== 2'd0) begin
      errors++;
      $display("FAIL R1: got mode=%0b bank=%0d in reset, expected 0/0", enh_mode, bank_sel);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (enh_mode !== 1'b0 || bank_sel !== 2'd0) begin
      errors++;
      $display("FAIL R1: got mode=%0b bank=%0d after reset, expected 0/0", enh_mode, bank_sel);
    end
  endtask

  initial begin
    #4ms;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R4: wrong final byte, no unlock; R9: bank codes ignored in standard mode
    wr(7, 8'h07, "R4"); wr(7, 8'h0D, "R4"); wr(7, 8'h06, "R4"); wr(7, 8'h11, "R4");
    wr(7, 8'h40, "R9"); wr(7, 8'h80, "R9");
    idle(2);

    // R4: repeated 07h counts as first key byte, then unlock (R2, R3)
    wr(7, 8'h07, "R4"); wr(7, 8'h07, "R4"); wr(7, 8'h0D, "R4");
    wr(7, 8'h06, "R2"); wr(7, 8'h12, "R3");
    idle(1);

    // R6, R7: bank codes and ignored values
    wr(7, 8'h40, "R6"); wr(7, 8'h33, "R7"); wr(7, 8'hC0, "R7");
    wr(7, 8'h80, "R6"); wr(5, 8'h00, "R7"); wr(7, 8'h41, "R7");
    wr(7, 8'h00, "R6"); wr(7, 8'h40, "R6");
    // R8: key bytes again do not change mode
    wr(7, 8'h07, "R8"); wr(7, 8'h0D, "R8"); wr(7, 8'h06, "R8"); wr(7, 8'h12, "R8");
    idle(3);

    // R1: reset returns to standard and discards a half key
    do_reset();
    wr(7, 8'h07, "R1"); wr(7, 8'h0D, "R1");
    do_reset();
    wr(7, 8'h06, "R1"); wr(7, 8'h12, "R1");
    idle(2);

    // R5: other-port writes interleaved with the key
    wr(7, 8'h07, "R5"); wr(3, 8'h55, "R5"); wr(7, 8'h0D, "R5");
    wr(2, 8'h12, "R5"); wr(0, 8'h07, "R5"); wr(7, 8'h06, "R5");
    wr(6, 8'hFF, "R5"); wr(7, 8'h12, "R5");
    idle(1);
    wr(7, 8'h80, "R6");
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule